// File: doc/BRIEF.md
# Printer Port Register Block

This block is a byte-wide register file for a standard printer port that also plays the part of a simple printer attached to it. A host reaches it over a small register bus with a three-bit offset, separate read and write strobes, an eight-bit write byte and an eight-bit read byte. Three offsets are live: the data byte, the status byte and the control byte. Every other offset reads as all ones and ignores writes.

The printer side lives inside the block. Software toggles the strobe bit in the control byte. The block then drops not-busy, sends the stored output byte out on a one-clock strobe, and walks the acknowledge/busy sequence forward each time status is read. A separate input latch, loaded from outside, supplies the data byte when the direction bit selects input. When interrupts are enabled, a strobe release sets a pending flag. That flag drives the interrupt line until status is read.

Top module: `prn_port_regs`

## Requirements
- R1: After reset the output data byte and the input latch both hold 0xFF, status reads 0xD9, control reads 0xCC, and `irq` and `byteOutValid` are low.
- R2: Only offsets 0 (data), 1 (status) and 2 (control) are live. Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change nothing.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and offset 2 reads it back. Control bits: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init, 1 auto-linefeed, 0 strobe.
- R4: A control write with bit 2 (init) clear loads status with 0xD8. Status bits: 7 not-busy, 6 acknowledge, 5 paper-out, 4 online, 3 not-error, 0 timeout.
- R5: A control write with init and select both set and strobe set clears status bit 7. If the stored strobe bit was 0 before that write, the block also pulses `byteOutValid` in the next cycle, with `byteOut` equal to the last byte written to offset 0.
- R6: A control write with init and select set and strobe clear sets the interrupt-pending flag when bit 4 of the stored control byte is already 1. `irq` follows that flag from the next cycle.
- R7: A read of offset 0 returns the input latch when control bit 5 is 1, and the last written output byte otherwise. The input latch loads `extData` on any cycle with `extLoad` high.
- R8: A status read returns the status held before that cycle. It then clears the interrupt-pending flag. If status bit 7 and the stored strobe bit are both 0, it clears status bit 6 when bit 6 is set, and otherwise sets bits 6 and 7.
- R9: Read side effects take place only in a cycle with `busRd` high and `busWr` low. When both strobes are high, the write acts and the read changes no state.
- R10: `byteOutValid` lasts exactly one clock, and `byteOut` holds its value throughout that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte, combinational, taken from state before the current edge |
| extLoad | input | 1 | Loads the input latch |
| extData | input | 8 | Byte for the input latch |
| byteOutValid | output | 1 | One-clock strobe for a released output byte |
| byteOut | output | 8 | Released output byte |
| irq | output | 1 | Level interrupt |

## Verification
Assertions check these rules on every cycle:
- control bits 7:6 always come back as ones after a write;
- an init-low write forces status to 0xD8;
- the output strobe never lasts two cycles and carries the current output byte;
- the interrupt only rises after a control write and always falls after a status read;
- a write blocks any read side effect.

Only the bench's scenarios can show the multi-step handshake. That covers the acknowledge/busy walk across several status reads, edge detection against the stored strobe bit, the direction-selected data read, and the case where a read and a write coincide. The bench checks these against a reference model that it keeps from the requirements.

// File: rtl/prn_pkg.sv
`timescale 1ns/1ps
package prn_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 3'd2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [DATA_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [DATA_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [DATA_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [DATA_W-1:0] CTL_RST    = 8'hCC;
  localparam logic [DATA_W-1:0] CTL_FORCE  = 8'hC0;
  localparam logic [DATA_W-1:0] IDLE_READ  = 8'hFF;

  typedef enum logic [1:0] {
    RD_DATA = 2'd0,
    RD_STAT = 2'd1,
    RD_CTL  = 2'd2,
    RD_NONE = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic   wrData;
    logic   wrCtl;
    logic   rdStat;
    rdSel_t rdSel;
  } prnStrobe_t;
endpackage

// File: rtl/prn_ctrl.sv
`timescale 1ns/1ps
module prn_ctrl
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output prnStrobe_t        strb
);
  always_comb begin
    strb.wrData = busWr && (busAddr == OFF_DATA);
    strb.wrCtl  = busWr && (busAddr == OFF_CTL);
    // read side effects are suppressed by a write in the same cycle
    strb.rdStat = busRd && !busWr && (busAddr == OFF_STAT);
    unique case (busAddr)
      OFF_DATA: strb.rdSel = RD_DATA;
      OFF_STAT: strb.rdSel = RD_STAT;
      OFF_CTL:  strb.rdSel = RD_CTL;
      default:  strb.rdSel = RD_NONE;
    endcase
  end

  a_r9_write_blocks_read: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> !strb.rdStat);

  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrCtl, strb.rdStat}));
endmodule

// File: rtl/prn_datapath.sv
`timescale 1ns/1ps
module prn_datapath
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  prnStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              extLoad,
  input  logic [DATA_W-1:0] extData,
  output logic [DATA_W-1:0] busRdata,
  output logic              byteOutValid,
  output logic [DATA_W-1:0] byteOut,
  output logic              irq
);
  logic [DATA_W-1:0] dataOut, dataIn, statReg, ctlReg;
  logic              irqPend;
  logic              selStrobeOn;   // init and select both high in written byte
  logic              handshakeStep; // status read may advance ack/busy

  assign selStrobeOn   = busWdata[CT_INIT] && busWdata[CT_SEL];
  assign handshakeStep = !statReg[ST_NBUSY] && !ctlReg[CT_STB];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut      <= DATA_RST;
      dataIn       <= DATA_RST;
      statReg      <= STAT_RST;
      ctlReg       <= CTL_RST;
      irqPend      <= 1'b0;
      byteOutValid <= 1'b0;
      byteOut      <= DATA_RST;
    end else begin
      byteOutValid <= 1'b0;
      if (extLoad) dataIn <= extData;
      if (strb.wrData) dataOut <= busWdata;
      if (strb.wrCtl) begin
        ctlReg <= busWdata | CTL_FORCE;
        if (!busWdata[CT_INIT]) begin
          statReg <= STAT_INIT;
        end else if (selStrobeOn) begin
          if (busWdata[CT_STB]) begin
            statReg[ST_NBUSY] <= 1'b0;
            if (!ctlReg[CT_STB]) begin
              byteOutValid <= 1'b1;
              byteOut      <= dataOut;
            end
          end else if (ctlReg[CT_IEN]) begin
            irqPend <= 1'b1;
          end
        end
      end
      if (strb.rdStat) begin
        irqPend <= 1'b0;
        if (handshakeStep) begin
          if (statReg[ST_ACK]) begin
            statReg[ST_ACK] <= 1'b0;
          end else begin
            statReg[ST_ACK]   <= 1'b1;
            statReg[ST_NBUSY] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_DATA: busRdata = ctlReg[CT_DIR] ? dataIn : dataOut;
      RD_STAT: busRdata = statReg;
      RD_CTL:  busRdata = ctlReg;
      default: busRdata = IDLE_READ;
    endcase
  end

  assign irq = irqPend;

  a_r3_ctl_forced_top: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtl |=> (busRdata == busRdata) && ctlReg[7:6] == 2'b11 &&
                   ctlReg[5:0] == $past(busWdata[5:0]));

  a_r4_init_low_status: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtl && !busWdata[CT_INIT]) |=> statReg == STAT_INIT);

  a_r5_release_byte: assert property (@(posedge clk) disable iff (!rstN)
    byteOutValid |-> byteOut == dataOut);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteOutValid |=> !byteOutValid);

  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strb.wrCtl));

  a_r8_read_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStat |=> !irq);
endmodule

// File: rtl/prn_port_regs.sv
`timescale 1ns/1ps
module prn_port_regs
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              extLoad,
  input  logic [DATA_W-1:0] extData,
  output logic              byteOutValid,
  output logic [DATA_W-1:0] byteOut,
  output logic              irq
);
  prnStrobe_t strb;

  prn_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strb    (strb)
  );

  prn_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWdata     (busWdata),
    .extLoad      (extLoad),
    .extData      (extData),
    .busRdata     (busRdata),
    .byteOutValid (byteOutValid),
    .byteOut      (byteOut),
    .irq          (irq)
  );
endmodule

// File: tb/prn_port_regs_tb.sv
`timescale 1ns/1ps
module prn_port_regs_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] busAddr;
  logic       busRd, busWr, extLoad;
  logic [7:0] busWdata, extData, busRdata, byteOut;
  logic       byteOutValid, irq;

  int nChecks = 0;
  int nErrors = 0;

  // reference state
  logic [7:0] mOut, mIn, mStat, mCtl, mByte;
  logic       mIrq, mBov;

  always #5 clk = ~clk;

  prn_port_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .extLoad(extLoad), .extData(extData),
    .byteOutValid(byteOutValid), .byteOut(byteOut), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(logic [2:0] a);
    case (a)
      3'd0:    return mCtl[5] ? mIn : mOut;
      3'd1:    return mStat;
      3'd2:    return mCtl;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string readTag(logic [2:0] a);
    case (a)
      3'd0:    return "R7";
      3'd1:    return "R8";
      3'd2:    return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic modelStep(bit rd, bit wr, logic [2:0] a, logic [7:0] wd,
                           bit ld, logic [7:0] ed);
    logic [7:0] oOut, oStat, oCtl;
    oOut = mOut; oStat = mStat; oCtl = mCtl;
    mBov = 1'b0;
    if (ld) mIn = ed;
    if (wr && a == 3'd0) mOut = wd;
    if (wr && a == 3'd2) begin
      mCtl = wd | 8'hC0;
      if (!wd[2]) mStat = 8'hD8;
      else if (wd[3]) begin
        if (wd[0]) begin
          mStat[7] = 1'b0;
          if (!oCtl[0]) begin mBov = 1'b1; mByte = oOut; end
        end else if (oCtl[4]) mIrq = 1'b1;
      end
    end
    if (rd && !wr && a == 3'd1) begin  // R9: write suppresses read effects
      mIrq = 1'b0;
      if (!oStat[7] && !oCtl[0]) begin
        if (oStat[6]) mStat[6] = 1'b0;
        else begin mStat[6] = 1'b1; mStat[7] = 1'b1; end
      end
    end
  endtask

  task automatic op(bit rd, bit wr, logic [2:0] a, logic [7:0] wd,
                    bit ld = 0, logic [7:0] ed = 8'h00);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busWdata = wd;
    extLoad = ld; extData = ed;
    #1;
    if (rd) chk(readTag(a), busRdata, expRead(a));
    modelStep(rd, wr, a, wd, ld, ed);
    @(posedge clk); #1;
    chk("R6", {7'd0, irq}, {7'd0, mIrq});
    chk("R10", {7'd0, byteOutValid}, {7'd0, mBov});
    if (mBov) chk("R5", byteOut, mByte);
  endtask

  initial begin
    #1_000_000;
    nErrors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; busRd = 0; busWr = 0; busAddr = 0; busWdata = 0;
    extLoad = 0; extData = 0;
    mOut = 8'hFF; mIn = 8'hFF; mStat = 8'hD9; mCtl = 8'hCC; mByte = 8'hFF;
    mIrq = 0; mBov = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    chk("R1", {7'd0, irq}, 8'd0);
    chk("R1", {7'd0, byteOutValid}, 8'd0);
    op(1, 0, 3'd0, 0); op(1, 0, 3'd1, 0); op(1, 0, 3'd2, 0);
    // R2 idle offsets and ignored writes
    op(1, 0, 3'd5, 0); op(0, 1, 3'd1, 8'h00); op(0, 1, 3'd6, 8'h12);
    op(1, 0, 3'd1, 0); op(1, 0, 3'd7, 0);
    // R5 strobe release and handshake walk (R8)
    op(0, 1, 3'd0, 8'h5A);
    op(0, 1, 3'd2, 8'h0C);
    op(0, 1, 3'd2, 8'h0D);   // release 0x5A
    op(0, 1, 3'd2, 8'h0D);   // no second release
    op(1, 0, 3'd1, 0);
    op(0, 1, 3'd2, 8'h0C);
    op(1, 0, 3'd1, 0); op(1, 0, 3'd1, 0); op(1, 0, 3'd1, 0);
    // R6 interrupt, R9 simultaneous read and write, R8 clear
    op(0, 1, 3'd2, 8'h1C);
    op(0, 1, 3'd2, 8'h1C);
    op(1, 1, 3'd1, 8'h00);   // R9: irq must remain set
    op(1, 0, 3'd1, 0);
    // R4 init low
    op(0, 1, 3'd2, 8'h00); op(1, 0, 3'd1, 0); op(1, 0, 3'd2, 0);
    // R7 direction select
    op(0, 0, 3'd0, 0, 1, 8'h3C);
    op(0, 1, 3'd2, 8'h2C); op(1, 0, 3'd0, 0);
    op(0, 1, 3'd2, 8'h0C); op(1, 0, 3'd0, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [2:0] a;
      logic [7:0] wd;
      k = $urandom % 10;
      a = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
      wd = 8'($urandom);
      if (a == 3'd2 && ($urandom % 4 != 0)) wd[3:2] = 2'b11;
      op(k < 4 || k == 8, (k >= 4 && k < 8) || k == 8, a, wd,
         ($urandom % 8) == 0, 8'($urandom));
    end
    op(0, 0, 3'd0, 0);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule